// File: doc/BRIEF.md
# Strobed Serial-to-Parallel Output Expander

This block widens a host's output capability. Over four wires (serial data, shift clock, strobe and an active-low clear) a host drives a register of parallel output bits. Bits move into an internal shift register on each rising edge of the shift clock. A latch stage sits between the shift register and the outputs. While the strobe is high, the latch keeps its value and the outputs do not move during shifting. While the strobe is low, the latch is transparent, so the outputs follow the shift register. A high-to-low strobe transition therefore publishes a finished word. Clear forces the latch to zero and leaves the shift register untouched.

All four host lines are asynchronous to the block clock. Each line passes through a two-flop synchroniser, and shift-clock rising edges are detected in the block clock domain. A shift and a transparent latch update that happen in the same cycle are folded into one register step. The outputs never show a stale word for an extra cycle.

Top module: `sipo_expander`

## Requirements
- R1: While rst_ni is low, par_o is 0 and the shift register is 0. The synchronisers take the idle host levels: clear high, strobe high, shift clock low, data low.
- R2: Each rising edge of ser_clk_i shifts ser_dat_i into bit 0 of the shift register (output P1), and every older bit moves one position toward bit WIDTH-1 (P8). After eight shifts, the first bit sent sits in bit 7. A falling edge or a steady level of ser_clk_i does not shift.
- R3: While strobe_i is high and clear_ni is high, par_o keeps its value, whatever shifting takes place.
- R4: When strobe_i goes from high to low, with clear_ni high, par_o takes the shift register contents.
- R5: While strobe_i is low and clear_ni is high, each shift appears on par_o in the same block cycle in which the shift register changes.
- R6: While clear_ni is low, par_o is 0 regardless of strobe_i and ser_clk_i, and shifts still update the shift register. Clear by itself does not alter the shift register.
- R7: When clear_ni returns high while strobe_i is low, par_o takes the current shift register contents.
- R8: A change on a host line reaches par_o at the third rising edge of clk_i after it is applied (two synchroniser stages plus one register stage), and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_dat_i | input | 1 | Serial data from host |
| ser_clk_i | input | 1 | Host shift clock, rising edge active |
| strobe_i | input | 1 | High: latch holds; low: latch transparent |
| clear_ni | input | 1 | Active-low clear of the output latch |
| par_o | output | WIDTH | Parallel outputs, bit 0 = P1 |

## Verification
The shift register update and the transparent latch load can fall in the same block cycle. This happens when a synchronised shift-clock rising edge arrives while the strobe is low, or when the strobe falls on the same cycle as the shift edge. The bench drives ser_clk_i high and strobe_i low in the same step. It checks that par_o already holds the post-shift word, not the pre-shift one, and that clear still wins when it is asserted on that same cycle. Random mixes of shifts, strobe toggles and clear pulses then run against a reference model of the shift register and the latch.

// File: rtl/xp_pkg.sv
package xp_pkg;
  typedef struct packed {
    logic dat;
    logic sclk;
    logic stb;
    logic clr_n;
  } host_t;

  localparam int HOST_BITS = $bits(host_t);
  localparam host_t HOST_IDLE = '{dat: 1'b0, sclk: 1'b0, stb: 1'b1, clr_n: 1'b1};
endpackage

// File: rtl/xp_sync.sv
module xp_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  // R1
  initial rst_val_chk: assert (STAGES >= 1);
endmodule

// File: rtl/xp_shift.sv
module xp_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         dat_i,
  output logic         shift_o,
  output logic [W-1:0] sr_o,
  output logic [W-1:0] sr_next_o
);
  logic sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_i;
  end

  assign shift_o   = sclk_i & ~sclk_d_q;
  assign sr_next_o = shift_o ? {sr_o[W-2:0], dat_i} : sr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_o <= '0;
    else         sr_o <= sr_next_o;
  end

  // R2
  no_shift_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_i |=> $stable(sr_o));
  // R2
  no_shift_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && $past(sclk_i)) |=> $stable(sr_o));
endmodule

// File: rtl/xp_latch.sv
module xp_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_ni,
  input  logic         stb_i,
  input  logic [W-1:0] sr_next_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (!clr_ni) q_o <= '0;
    else if (!stb_i)  q_o <= sr_next_i;  // transparent, takes post-shift word
  end

  // R6
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> q_o == '0);
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && stb_i) |=> $stable(q_o));
endmodule

// File: rtl/sipo_expander.sv
module sipo_expander #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_dat_i,
  input  logic             ser_clk_i,
  input  logic             strobe_i,
  input  logic             clear_ni,
  output logic [WIDTH-1:0] par_o
);
  import xp_pkg::*;

  host_t            host_raw, host_s;
  logic             shift;
  logic [WIDTH-1:0] sr, sr_next;

  assign host_raw = '{dat: ser_dat_i, sclk: ser_clk_i, stb: strobe_i, clr_n: clear_ni};

  xp_sync #(
    .W      (HOST_BITS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(HOST_IDLE)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (host_raw),
    .q_o   (host_s)
  );

  xp_shift #(.W(WIDTH)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (host_s.sclk),
    .dat_i    (host_s.dat),
    .shift_o  (shift),
    .sr_o     (sr),
    .sr_next_o(sr_next)
  );

  xp_latch #(.W(WIDTH)) i_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_ni   (host_s.clr_n),
    .stb_i    (host_s.stb),
    .sr_next_i(sr_next),
    .q_o      (par_o)
  );

  // R5
  transparent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_s.clr_n && !host_s.stb) |=> par_o == sr);
  // R6
  clr_keeps_sr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_s.clr_n && !shift) |=> $stable(sr));
endmodule

// File: tb/test_sipo_expander.sv
module test_sipo_expander;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dat = 1'b0, sclk = 1'b0, stb = 1'b1, clr_n = 1'b1;
  logic [W-1:0] par;

  int nvec = 0, nerr = 0;
  logic [W-1:0] sr_m = '0, lat_m = '0;
  logic sclk_prev = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  sipo_expander i_sipo_expander (
    .clk_i(clk), .rst_ni(rst_ni), .ser_dat_i(dat), .ser_clk_i(sclk),
    .strobe_i(stb), .clear_ni(clr_n), .par_o(par)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [W-1:0] exp);
    nvec++;
    if (par !== exp) begin
      nerr++;
      $display("FAIL %s par_o=%h expected=%h", tag, par, exp);
    end
  endtask

  function automatic logic [W-1:0] next_lat(logic [W-1:0] l, logic [W-1:0] s, logic c, logic st);
    if (!c) return '0;
    if (!st) return s;
    return l;
  endfunction

  // drive all four lines at once, let them settle, update model and compare
  task automatic apply(string tag, logic d, logic k, logic st, logic c);
    dat = d; sclk = k; stb = st; clr_n = c;
    tick(4);
    if (k && !sclk_prev) sr_m = {sr_m[W-2:0], d};
    sclk_prev = k;
    lat_m = next_lat(lat_m, sr_m, c, st);
    chk(tag, lat_m);
  endtask

  task automatic shift_bit(string tag, logic d, logic st, logic c);
    apply(tag, d, 1'b1, st, c);
    apply(tag, d, 1'b0, st, c);
  endtask

  initial begin
    logic [7:0] first_word;
    void'($urandom(32'd1234));
    tick(3);
    chk("R1 reset", 8'h00);
    rst_ni = 1'b1;
    tick(2);
    chk("R1 after release", 8'h00);

    // R3: shift eight bits with strobe high, outputs held
    first_word = 8'hB2;
    for (int i = 7; i >= 0; i--) shift_bit("R3 hold while shifting", first_word[i], 1'b1, 1'b1);
    // R4 and R2: strobe falls, first bit at bit 7
    apply("R4 strobe fall", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2 bit order", 8'hB2);
    // R5: transparent shift
    shift_bit("R5 transparent shift", 1'b1, 1'b0, 1'b1);
    chk("R5 word", 8'h65);
    // R2: falling edge does not shift
    apply("R2 no shift on fall", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2 no shift", 8'h65);
    // R6: clear during a transparent shift
    apply("R6 clear with shift", 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 zero", 8'h00);
    apply("R6 clear", 1'b0, 1'b0, 1'b0, 1'b0);
    // R7: release clear with strobe low
    apply("R7 release", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 word", 8'hCA);
    // R6: clear alone leaves shift register intact
    apply("R6 clear strobe high", 1'b0, 1'b0, 1'b1, 1'b0);
    apply("R6 release strobe high", 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 still zero", 8'h00);
    apply("R6 sr kept", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 sr kept", 8'hCA);

    // R8: latency of a strobe fall
    apply("R8 prep", 1'b0, 1'b0, 1'b1, 1'b1);
    shift_bit("R8 prep shift", 1'b1, 1'b1, 1'b1);
    chk("R8 held", 8'hCA);
    stb = 1'b0;
    tick(2);
    chk("R8 not before third edge", 8'hCA);
    tick(1);
    chk("R8 at third edge", 8'h95);
    lat_m = sr_m;

    // same-cycle: shift edge and strobe fall together
    apply("R5 prep", 1'b0, 1'b0, 1'b1, 1'b1);
    apply("R5 shift+strobe same cycle", 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R5 post-shift word", 8'h2A);
    // clear with shift edge and strobe low together
    apply("R6 prep", 1'b1, 1'b0, 1'b0, 1'b1);
    apply("R6 clear+shift same cycle", 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6 clear wins", 8'h00);
    apply("R7 release after shift", 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R7 shifted word", 8'h55);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic d, k, st, c;
      d  = 1'($urandom);
      k  = 1'($urandom);
      st = ($urandom % 3) != 0;
      c  = ($urandom % 8) != 0;
      apply("RND", d, k, st, c);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule